// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits on the host side of an asynchronous NOR-style flash bus and turns one-word requests into the command cycles the flash part expects. A request names a block erase, a word program or a plain array read, together with an address and, for a program, a data word. For an erase or a program the sequencer writes the two command cycles. It then reads the status byte again and again until the ready bit is set, and decodes the error bits in a fixed priority order. It always writes the read-array command before it reports a 3-bit result code. A plain array read is a single timed read cycle.

All bus timing comes from the system clock. Each timing minimum is a nanosecond parameter that is rounded up to whole clock periods. The write-enable low phase must satisfy the pulse width and the address and data setup times together. The chip-enable setup and hold phases surround that low phase, and a quiet gap follows to give the write-enable high time. Read cycles hold output enable low for the longer of the address and output-enable access times. They then release the bus for one cycle before any write may drive it.

The controller is a single state machine with eight states. After reset it stays in **BOOT** while it counts out the flash recovery time, then moves to **IDLE**. From **IDLE**, an erase or program request goes to **SETUP**, which writes 20h or 40h, and then to **CONFIRM**, which writes D0h or the data word. **CONFIRM** leads to **POLL**. **POLL** issues one status read and loops on itself while the part is busy. It leaves for **RESTORE** once the part is ready or the poll budget is used up. **RESTORE** writes FFh and goes to **DONE**. An array read goes from **IDLE** to **ARRAY_RD** and then to **DONE**. **DONE** lasts one cycle and returns to **IDLE**. A separate bus-cycle engine carries out each write or read for the states that use the bus.

Top module: `flash_seq`

## Requirements
- R1: While `rst_n` is low, `fl_rst_n` is low and chip enable, output enable and write enable are all high. After release, `req_ready` stays low for at least ceil(T_RST_NS/CLK_NS) cycles, and no write-enable falling edge occurs earlier than that.
- R2: An erase request (`req_op`=01) writes 20h and then D0h, both to the request address. Status reads follow until status bit 7 reads 1. A part that becomes ready after N busy reads is read N+1 times.
- R3: A program request (`req_op`=10) writes 40h and then the 16-bit request data, both to the request address. It then polls as in R2.
- R4: Write enable stays low for at least ceil(max(50,50,50 ns)/CLK_NS) cycles and high for at least ceil(30 ns/CLK_NS) cycles between pulses. Chip enable goes low at least ceil(10 ns/CLK_NS) cycles before write enable falls and stays low at least that long after write enable rises. Address and data do not change while write enable is low.
- R5: A read cycle holds output enable low for at least ceil(max(85,40 ns)/CLK_NS) cycles. Output enable is never low while write enable is low.
- R6: The masked status is evaluated in this order, giving these result codes: bit 3 gives 1 (supply), then bit 1 gives 2 (locked), then bits 5 and 4 both set give 3 (bad sequence). Otherwise the result is 0 (ok), apart from the cases in R7.
- R7: After R6, bit 5 alone gives 4 (erase failure) for an erase only. Bit 4 alone gives 5 (program failure) for a program only. Status bit 0 never changes a result.
- R8: If POLL_LIMIT consecutive status reads all show bit 7 at 0, polling stops after exactly POLL_LIMIT reads and the result is 6 (timeout). A part that becomes ready on read POLL_LIMIT still gives 0.
- R9: Every erase or program, including failed and timed-out ones, ends with a write of FFh as its last bus write.
- R10: An array read (`req_op`=00) performs no bus write, returns the word stored at the address on `rd_data`, and reports 0.
- R11: `done` is a one-cycle pulse after which `req_ready` is high again. While `req_ready` is high the bus is idle. A request with `req_op`=11 is ignored: no bus activity and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_op | input | 2 | 00 read, 01 erase, 10 program, 11 ignored |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | 16 | Word to program |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid from `done` until the next request ends |
| rd_data | output | 16 | Word returned by an array read |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq | inout | 16 | Flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_rst_n | output | 1 | Flash reset, active low |

## Verification
The command path is run against a behavioural flash part for every combination of status bits 5, 4, 3, 1 and 0, once as an erase and once as a program. This separates the priority order of R6 from the operation-dependent codes of R7, and shows that bit 0 is masked. The busy time before ready is varied. It is also pushed to one read short of the poll budget and then to the budget itself, which separates a late success from a timeout. Erase, program and read-back with different data show that the data word really travels on the bus. Timing monitors record the shortest write-enable, chip-enable and output-enable phases seen over the whole run and compare them with the rounded-up minima.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_ERASE = 2'b01,
        OP_PROG  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_SUPPLY  = 3'd1,
        RES_LOCKED  = 3'd2,
        RES_BADSEQ  = 3'd3,
        RES_ERASE   = 3'd4,
        RES_PROG    = 3'd5,
        RES_TIMEOUT = 3'd6
    } res_e;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int ns2cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // priority decode of a ready status byte; bit 0 is masked
    function automatic res_e decode_status(input op_e op, input logic [7:0] raw);
        logic [7:0] s;
        s = raw & 8'hFE;
        if (s[3])                       return RES_SUPPLY;
        else if (s[1])                  return RES_LOCKED;
        else if (s[5] && s[4])          return RES_BADSEQ;
        else if (op == OP_ERASE && s[5]) return RES_ERASE;
        else if (op == OP_PROG && s[4])  return RES_PROG;
        else                            return RES_OK;
    endfunction

endpackage

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int CE_SU   = 2,
    parameter int WE_LO   = 7,
    parameter int WR_HOLD = 2,
    parameter int WE_HI   = 4,
    parameter int RD_WAIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       data_i,
    input  logic [15:0]       dq_in,
    output logic              done,
    output logic [15:0]       rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n
);

    localparam int MAXC = imax(imax(imax(CE_SU, WE_LO), imax(WR_HOLD, WE_HI)), RD_WAIT);
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [2:0] {
        B_IDLE, B_WSETUP, B_WLOW, B_WHOLD, B_WGAP, B_RWAIT, B_RGAP
    } phase_e;

    phase_e            ph;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph     <= B_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            data_q <= '0;
            rdata  <= '0;
        end else if (ph == B_IDLE) begin
            if (start) begin
                addr_q <= addr_i;
                data_q <= data_i;
                ph     <= wr ? B_WSETUP : B_RWAIT;
                cnt    <= wr ? CW'(CE_SU - 1) : CW'(RD_WAIT - 1);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            unique case (ph)
                B_WSETUP: begin ph <= B_WLOW;  cnt <= CW'(WE_LO - 1);   end
                B_WLOW:   begin ph <= B_WHOLD; cnt <= CW'(WR_HOLD - 1); end
                B_WHOLD:  begin ph <= B_WGAP;  cnt <= CW'(WE_HI - 1);   end
                B_RWAIT:  begin ph <= B_RGAP;  cnt <= '0; rdata <= dq_in; end
                default:  ph <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        ce_n  = !(ph == B_WSETUP || ph == B_WLOW || ph == B_WHOLD || ph == B_RWAIT);
        we_n  = (ph != B_WLOW);
        oe_n  = (ph != B_RWAIT);
        dq_oe = (ph == B_WSETUP || ph == B_WLOW || ph == B_WHOLD);
        done  = (ph == B_WGAP || ph == B_RGAP) && (cnt == '0);
    end

    assign bus_addr = addr_q;
    assign dq_out   = data_q;

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int CLK_NS      = 8,
    parameter int T_WE_LO_NS  = 50,
    parameter int T_WE_HI_NS  = 30,
    parameter int T_CE_SU_NS  = 10,
    parameter int T_CE_HO_NS  = 10,
    parameter int T_AD_SU_NS  = 50,
    parameter int T_AD_HO_NS  = 5,
    parameter int T_DQ_SU_NS  = 50,
    parameter int T_DQ_HO_NS  = 5,
    parameter int T_ACC_NS    = 85,
    parameter int T_OE_ACC_NS = 40,
    parameter int T_RST_NS    = 1000,
    parameter int POLL_LIMIT  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_data,
    output logic              req_ready,
    output logic              done,
    output logic [2:0]        result,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] fl_addr,
    inout  wire  [15:0]       fl_dq,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              fl_rst_n
);

    localparam int WE_LO_C = ns2cyc(imax(T_WE_LO_NS, imax(T_AD_SU_NS, T_DQ_SU_NS)), CLK_NS);
    localparam int CE_SU_C = ns2cyc(T_CE_SU_NS, CLK_NS);
    localparam int HOLD_C  = ns2cyc(imax(T_CE_HO_NS, imax(T_AD_HO_NS, T_DQ_HO_NS)), CLK_NS);
    localparam int WE_HI_C = ns2cyc(T_WE_HI_NS, CLK_NS);
    localparam int RD_C    = ns2cyc(imax(T_ACC_NS, T_OE_ACC_NS), CLK_NS);
    localparam int RST_C   = ns2cyc(T_RST_NS, CLK_NS);
    localparam int BW      = $clog2(RST_C + 1);
    localparam int PW      = $clog2(POLL_LIMIT + 1);

    typedef enum logic [2:0] {
        S_BOOT, S_IDLE, S_SETUP, S_CONFIRM, S_POLL, S_RESTORE, S_ARRAY_RD, S_DONE
    } state_e;

    state_e            state, nxt;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       data_q;
    logic [PW-1:0]     poll_cnt;
    logic [BW-1:0]     boot_cnt;
    logic              issued;
    logic              fl_rst_q;
    res_e              result_q;
    logic [15:0]       rd_q;

    logic              bus_start, bus_wr, bus_done, dq_oe;
    logic [15:0]       bus_wdata, bus_rdata, dq_out;
    logic              poll_last, boot_last, take_req;

    assign poll_last = (poll_cnt == PW'(POLL_LIMIT - 1));
    assign boot_last = (boot_cnt == BW'(RST_C - 1));
    assign take_req  = req_valid && (op_e'(req_op) != OP_NONE);

    flash_bus_engine #(
        .ADDR_W (ADDR_W),
        .CE_SU  (CE_SU_C),
        .WE_LO  (WE_LO_C),
        .WR_HOLD(HOLD_C),
        .WE_HI  (WE_HI_C),
        .RD_WAIT(RD_C)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bus_start),
        .wr      (bus_wr),
        .addr_i  (addr_q),
        .data_i  (bus_wdata),
        .dq_in   (fl_dq),
        .done    (bus_done),
        .rdata   (bus_rdata),
        .bus_addr(fl_addr),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe),
        .ce_n    (fl_ce_n),
        .oe_n    (fl_oe_n),
        .we_n    (fl_we_n)
    );

    assign fl_dq = dq_oe ? dq_out : 16'hzzzz;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:     if (fl_rst_q && boot_last) nxt = S_IDLE;
            S_IDLE:     if (take_req) nxt = (op_e'(req_op) == OP_READ) ? S_ARRAY_RD : S_SETUP;
            S_SETUP:    if (bus_done) nxt = S_CONFIRM;
            S_CONFIRM:  if (bus_done) nxt = S_POLL;
            S_POLL:     if (bus_done) nxt = (bus_rdata[7] || poll_last) ? S_RESTORE : S_POLL;
            S_RESTORE:  if (bus_done) nxt = S_DONE;
            S_ARRAY_RD: if (bus_done) nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_BOOT;
        endcase
    end

    // outputs of each state
    always_comb begin
        bus_wr    = 1'b0;
        bus_wdata = '0;
        bus_start = 1'b0;
        unique case (state)
            S_SETUP: begin
                bus_wr    = 1'b1;
                bus_wdata = {8'h00, (op_q == OP_ERASE) ? CMD_ERASE : CMD_PROG};
                bus_start = !issued;
            end
            S_CONFIRM: begin
                bus_wr    = 1'b1;
                bus_wdata = (op_q == OP_ERASE) ? {8'h00, CMD_CONFIRM} : data_q;
                bus_start = !issued;
            end
            S_RESTORE: begin
                bus_wr    = 1'b1;
                bus_wdata = {8'h00, CMD_ARRAY};
                bus_start = !issued;
            end
            S_POLL, S_ARRAY_RD: bus_start = !issued;
            default: ;
        endcase
        req_ready = (state == S_IDLE);
        done      = (state == S_DONE);
    end

    // request capture, counters and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_READ;
            addr_q   <= '0;
            data_q   <= '0;
            poll_cnt <= '0;
            boot_cnt <= '0;
            issued   <= 1'b0;
            fl_rst_q <= 1'b0;
            result_q <= RES_OK;
            rd_q     <= '0;
        end else begin
            fl_rst_q <= 1'b1;
            if (state == S_BOOT && fl_rst_q && !boot_last) boot_cnt <= boot_cnt + 1'b1;
            if (bus_done)       issued <= 1'b0;
            else if (bus_start) issued <= 1'b1;
            if (state == S_IDLE && take_req) begin
                op_q     <= op_e'(req_op);
                addr_q   <= req_addr;
                data_q   <= req_data;
                poll_cnt <= '0;
            end
            if (state == S_POLL && bus_done) begin
                if (bus_rdata[7])   result_q <= decode_status(op_q, bus_rdata[7:0]);
                else if (poll_last) result_q <= RES_TIMEOUT;
                else                poll_cnt <= poll_cnt + 1'b1;
            end
            if (state == S_ARRAY_RD && bus_done) begin
                rd_q     <= bus_rdata;
                result_q <= RES_OK;
            end
        end
    end

    assign result   = result_q;
    assign rd_data  = rd_q;
    assign fl_rst_n = fl_rst_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fl_ce_n,
    input logic fl_oe_n,
    input logic fl_we_n,
    input logic fl_rst_n,
    input logic req_ready,
    input logic done
);

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_oe_n);

    assert_ce_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> (!fl_ce_n && $past(!fl_ce_n)));

    assert_ce_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> !fl_ce_n);

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |=> !fl_we_n);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_no_write_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rst_n |-> (fl_we_n && !req_ready));

endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_ce_n  (fl_ce_n),
    .fl_oe_n  (fl_oe_n),
    .fl_we_n  (fl_we_n),
    .fl_rst_n (fl_rst_n),
    .req_ready(req_ready),
    .done     (done)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;

    localparam int AW     = 8;
    localparam int CLK    = 8;
    localparam int PLIM   = 6;
    localparam int WE_LO_EXP = (50 + CLK - 1) / CLK;
    localparam int WE_HI_EXP = (30 + CLK - 1) / CLK;
    localparam int CE_SU_EXP = (10 + CLK - 1) / CLK;
    localparam int CE_HO_EXP = (10 + CLK - 1) / CLK;
    localparam int RD_EXP    = (85 + CLK - 1) / CLK;
    localparam int RST_EXP   = (1000 + CLK - 1) / CLK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic req_ready, done;
    logic [2:0] result;
    logic [15:0] rd_data;
    logic [AW-1:0] fl_addr;
    wire  [15:0] fl_dq;
    logic fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_seq #(.ADDR_W(AW), .CLK_NS(CLK), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done(done), .result(result), .rd_data(rd_data), .fl_addr(fl_addr),
        .fl_dq(fl_dq), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_rst_n(fl_rst_n)
    );

    // ---------------- behavioural flash part ----------------
    localparam int M_ARR = 0, M_STAT = 1, M_ESET = 2, M_PSET = 3;
    logic [15:0] mem [256];
    int mode = M_ARR;
    logic [7:0] inj = 8'h00;
    logic [7:0] cur_stat = 8'h00;
    int busy_n = 0;
    bit never = 1'b0;
    int st_reads = 0;
    int read_base = 0;
    int wr_cnt = 0;
    logic [15:0] wlog [64];
    logic [AW-1:0] alog [64];
    bit stat_rd = 1'b0;
    logic st_ready;
    logic [15:0] model_q;

    assign st_ready = !never && ((st_reads - read_base) >= busy_n);
    assign model_q  = (mode == M_STAT) ? {8'h00, st_ready, cur_stat[6:0]} : mem[fl_addr];
    assign fl_dq    = (!fl_ce_n && !fl_oe_n) ? model_q : 16'hzzzz;

    initial for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 3);

    always @(posedge fl_we_n or negedge fl_rst_n) begin
        if (!fl_rst_n) begin
            mode = M_ARR;
        end else if (!fl_ce_n) begin
            wlog[wr_cnt % 64] = fl_dq;
            alog[wr_cnt % 64] = fl_addr;
            wr_cnt++;
            case (mode)
                M_ESET: begin
                    read_base = st_reads;
                    if (fl_dq[7:0] == 8'hD0) begin
                        cur_stat = inj;
                        if ((inj & 8'hFE) == 8'h00)
                            for (int k = 0; k < 16; k++) mem[{fl_addr[7:4], 4'(k)}] = 16'hFFFF;
                    end else cur_stat = 8'h30;
                    mode = M_STAT;
                end
                M_PSET: begin
                    read_base = st_reads;
                    cur_stat = inj;
                    if ((inj & 8'hFE) == 8'h00) mem[fl_addr] = mem[fl_addr] & fl_dq;
                    mode = M_STAT;
                end
                default: begin
                    case (fl_dq[7:0])
                        8'hFF: mode = M_ARR;
                        8'h20: mode = M_ESET;
                        8'h40: mode = M_PSET;
                        8'h70: mode = M_STAT;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always @(negedge fl_oe_n) stat_rd = (mode == M_STAT);
    always @(posedge fl_oe_n) if (stat_rd) st_reads++;

    // ---------------- bus timing monitors ----------------
    int min_we_lo = 1000, min_we_hi = 1000, min_ce_su = 1000, min_ce_ho = 1000;
    int min_oe_lo = 1000, first_we = -1;
    int stab_viol = 0, cont_viol = 0, ce_low_cnt = 0;
    int we_lo_run = 0, we_hi_run = 0, ce_lo_run = 0, oe_lo_run = 0, ho_run = 0, since_rst = 0;
    bit prev_we = 1'b1, prev_ce = 1'b1, prev_oe = 1'b1, seen_fall = 1'b0, in_hold = 1'b0;
    logic [AW-1:0] lat_a;
    logic [15:0] lat_d;

    always @(negedge clk) begin
        if (!fl_ce_n) ce_low_cnt++;
        if (!fl_we_n && !fl_oe_n) cont_viol++;
        if (prev_we && !fl_we_n) begin
            if (ce_lo_run < min_ce_su) min_ce_su = ce_lo_run;
            if (seen_fall && we_hi_run < min_we_hi) min_we_hi = we_hi_run;
            if (first_we < 0) first_we = since_rst;
            seen_fall = 1'b1;
            lat_a = fl_addr;
            lat_d = fl_dq;
        end
        if (!fl_we_n && (fl_addr !== lat_a || fl_dq !== lat_d)) stab_viol++;
        if (!prev_we && fl_we_n) begin
            if (we_lo_run < min_we_lo) min_we_lo = we_lo_run;
            in_hold = 1'b1;
            ho_run = 0;
        end
        if (in_hold && fl_we_n) begin
            if (fl_ce_n) begin
                if (ho_run < min_ce_ho) min_ce_ho = ho_run;
                in_hold = 1'b0;
            end else ho_run++;
        end
        if (!prev_oe && fl_oe_n && oe_lo_run < min_oe_lo) min_oe_lo = oe_lo_run;
        we_lo_run = fl_we_n ? 0 : we_lo_run + 1;
        we_hi_run = fl_we_n ? we_hi_run + 1 : 0;
        ce_lo_run = fl_ce_n ? 0 : ce_lo_run + 1;
        oe_lo_run = fl_oe_n ? 0 : oe_lo_run + 1;
        if (fl_rst_n) since_rst++;
        prev_we = fl_we_n; prev_ce = fl_ce_n; prev_oe = fl_oe_n;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(input bit erase, input logic [7:0] raw);
        logic [7:0] s;
        s = raw & 8'hFE;
        if (s[3]) return 1;
        if (s[1]) return 2;
        if (s[5] && s[4]) return 3;
        if (erase && s[5]) return 4;
        if (!erase && s[4]) return 5;
        return 0;
    endfunction

    int wr_base, rd_base0;

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                          output int res, output logic [15:0] rdv);
        while (!req_ready) @(negedge clk);
        wr_base  = wr_cnt;
        rd_base0 = st_reads;
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        res = int'(result);
        rdv = rd_data;
        @(negedge clk);
        chk(!done && req_ready, "R11", "done one cycle then ready", {done, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int res;
        int cyc;
        logic [15:0] rdv;

        repeat (3) @(negedge clk);
        chk(fl_rst_n == 1'b0, "R1", "flash reset held", fl_rst_n, 0);
        chk({fl_ce_n, fl_oe_n, fl_we_n} == 3'b111, "R1", "bus idle in reset",
            {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
        chk(req_ready == 1'b0, "R1", "not ready in reset", req_ready, 0);
        rst_n = 1'b1;
        cyc = 0;
        while (!req_ready) begin @(negedge clk); cyc++; end
        chk(cyc >= RST_EXP, "R1", "recovery cycles", cyc, RST_EXP);

        // erase, ready after two busy reads
        inj = 8'h00; busy_n = 2;
        run_op(2'b01, 8'h13, 16'h0000, res, rdv);
        chk(res == 0, "R2", "erase result", res, 0);
        chk(wr_cnt - wr_base == 3, "R2", "erase write count", wr_cnt - wr_base, 3);
        chk(wlog[wr_base % 64][7:0] == 8'h20, "R2", "erase setup cmd", wlog[wr_base % 64], 8'h20);
        chk(wlog[(wr_base + 1) % 64][7:0] == 8'hD0, "R2", "erase confirm", wlog[(wr_base + 1) % 64], 8'hD0);
        chk(alog[wr_base % 64] == 8'h13 && alog[(wr_base + 1) % 64] == 8'h13, "R2",
            "erase addresses", alog[(wr_base + 1) % 64], 8'h13);
        chk(st_reads - rd_base0 == 3, "R2", "status reads", st_reads - rd_base0, 3);
        chk(wlog[(wr_base + 2) % 64][7:0] == 8'hFF, "R9", "erase ends read-array", wlog[(wr_base + 2) % 64], 8'hFF);

        // program and read back
        busy_n = 1;
        run_op(2'b10, 8'h15, 16'hA5C3, res, rdv);
        chk(res == 0, "R3", "program result", res, 0);
        chk(wlog[wr_base % 64][7:0] == 8'h40, "R3", "program setup cmd", wlog[wr_base % 64], 8'h40);
        chk(wlog[(wr_base + 1) % 64] == 16'hA5C3, "R3", "program data", wlog[(wr_base + 1) % 64], 16'hA5C3);
        chk(alog[(wr_base + 1) % 64] == 8'h15, "R3", "program address", alog[(wr_base + 1) % 64], 8'h15);
        chk(wlog[(wr_base + 2) % 64][7:0] == 8'hFF, "R9", "program ends read-array", wlog[(wr_base + 2) % 64], 8'hFF);

        run_op(2'b00, 8'h15, 16'h0000, res, rdv);
        chk(rdv == 16'hA5C3 && res == 0, "R10", "read programmed word", rdv, 16'hA5C3);
        chk(wr_cnt == wr_base, "R10", "read makes no write", wr_cnt - wr_base, 0);
        run_op(2'b00, 8'h16, 16'h0000, res, rdv);
        chk(rdv == 16'hFFFF, "R10", "read erased word", rdv, 16'hFFFF);
        run_op(2'b00, 8'h05, 16'h0000, res, rdv);
        chk(rdv == 16'h1000 + 16'(5 * 3), "R10", "read untouched word", rdv, 16'h1000 + 16'(5 * 3));

        // sweep of status bit combinations for both operations
        for (int p = 0; p < 32; p++) begin
            for (int e = 0; e < 2; e++) begin
                logic [7:0] bits;
                bits = {2'b00, p[4], p[3], p[2], 1'b0, p[1], p[0]};
                inj = bits; busy_n = p % 3;
                run_op(e ? 2'b01 : 2'b10, 8'(8'h40 + p), 16'(16'h0F0F ^ p), res, rdv);
                chk(res == exp_code(e != 0, bits), (bits[3] | bits[1] | (bits[5] & bits[4])) ? "R6" : "R7",
                    $sformatf("status %02h op %0d", bits, e), res, exp_code(e != 0, bits));
                chk(wlog[(wr_cnt - 1) % 64][7:0] == 8'hFF, "R9", "last write read-array",
                    wlog[(wr_cnt - 1) % 64], 8'hFF);
            end
        end

        // poll budget boundaries
        inj = 8'h00; busy_n = PLIM - 1;
        run_op(2'b01, 8'h80, 16'h0000, res, rdv);
        chk(res == 0, "R8", "ready on last allowed read", res, 0);
        chk(st_reads - rd_base0 == PLIM, "R8", "reads at boundary", st_reads - rd_base0, PLIM);
        busy_n = PLIM;
        run_op(2'b10, 8'h81, 16'h1234, res, rdv);
        chk(res == 6, "R8", "timeout one past budget", res, 6);
        never = 1'b1;
        run_op(2'b01, 8'h82, 16'h0000, res, rdv);
        chk(res == 6, "R8", "timeout never ready", res, 6);
        chk(st_reads - rd_base0 == PLIM, "R8", "reads before timeout", st_reads - rd_base0, PLIM);
        chk(wlog[(wr_cnt - 1) % 64][7:0] == 8'hFF, "R9", "timeout ends read-array",
            wlog[(wr_cnt - 1) % 64], 8'hFF);
        never = 1'b0;

        // unused operation code
        begin
            int ce0;
            bit saw_done;
            ce0 = ce_low_cnt;
            saw_done = 1'b0;
            req_op = 2'b11; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (40) begin @(negedge clk); if (done) saw_done = 1'b1; end
            chk(!saw_done && ce_low_cnt == ce0 && req_ready, "R11", "op 11 ignored",
                ce_low_cnt - ce0, 0);
        end

        // timing summaries
        chk(min_we_lo >= WE_LO_EXP, "R4", "write-enable low", min_we_lo, WE_LO_EXP);
        chk(min_we_hi >= WE_HI_EXP, "R4", "write-enable high", min_we_hi, WE_HI_EXP);
        chk(min_ce_su >= CE_SU_EXP, "R4", "chip-enable setup", min_ce_su, CE_SU_EXP);
        chk(min_ce_ho >= CE_HO_EXP, "R4", "chip-enable hold", min_ce_ho, CE_HO_EXP);
        chk(stab_viol == 0, "R4", "address/data stable", stab_viol, 0);
        chk(min_oe_lo >= RD_EXP, "R5", "output-enable low", min_oe_lo, RD_EXP);
        chk(cont_viol == 0, "R5", "no bus contention", cont_viol, 0);
        chk(first_we >= RST_EXP, "R1", "first write after recovery", first_we, RST_EXP);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule